// File: doc/BRIEF.md
# EEPROM Write-Protection and Status Controller

This block keeps the status bits of a serial EEPROM and decides, request by request, whether the memory array or the status register may be written. It holds five bits of state. The busy flag is set while a programming cycle runs. The write-enable latch arms the next write. Two protection-level bits fence off part of the array. A lock-enable bit, together with an active-low hardware protect pin, can freeze the status register itself.

The serial front end decodes opcodes and presents one-cycle command strobes: arm, disarm, status write (with its data byte), array write start (with the target address) and programming done. The controller answers a granted write with a one-cycle grant pulse and sets busy. It answers a refused status write with a one-cycle reject pulse. The status byte is always visible for the front end to shift out. Serial shifting and the memory array live elsewhere. All pins are plain control and status lines, so there is no stream handshake and no back-pressure.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset the status byte is 0x00 and the grant and reject outputs are low.
- R2: While not busy, an arm strobe sets the write-enable latch (status bit 1) and a disarm strobe clears it, visible the cycle after the strobe.
- R3: An array write start while not busy is granted (arr_grant pulses the next cycle) only if the write-enable latch is set and the address lies outside the protected range.
- R4: Protection level (status bits 3:2) selects the fenced range from the two top address bits: 0 none, 1 the top quarter (top bits 11), 2 the top half (top bit 1), 3 the whole array. A fenced address is never granted.
- R5: A granted array or status write sets busy (status bit 0) together with its grant pulse. While busy, arm, disarm and write start have no effect, and status writes are refused.
- R6: A done strobe while busy clears both busy and the write-enable latch on the next cycle. A done strobe while idle has no effect.
- R7: With lock-enable (status bit 7) at 0, a status write with the latch set is granted whatever the pin level.
- R8: With lock-enable at 1 and the pin low, every status write is refused, so lock-enable cannot be cleared back to 0.
- R9: With the pin high, a status write with the latch set is granted whatever the lock-enable value.
- R10: Every refused status write leaves all status bits unchanged and gives a one-cycle sr_reject pulse, never together with sr_grant.
- R11: A granted status write loads data bit 7 into lock-enable and data bits 3:2 into the protection level. Status bits 6:4 always read 0.
- R12: When strobes coincide, only the highest one acts, in the order status write, write start, arm, disarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_wp_n | input | 1 | Hardware protect pin, low means protect |
| cmd_arm | input | 1 | Set write-enable latch strobe |
| cmd_disarm | input | 1 | Clear write-enable latch strobe |
| cmd_sr_wr | input | 1 | Status write request strobe |
| sr_din | input | 8 | Data byte for a status write |
| cmd_wr_start | input | 1 | Array write request strobe |
| wr_addr | input | ADDR_W | Target address of the array write |
| cmd_wr_done | input | 1 | Programming cycle finished strobe |
| arr_grant | output | 1 | One-cycle pulse: array write accepted |
| sr_grant | output | 1 | One-cycle pulse: status write accepted |
| sr_reject | output | 1 | One-cycle pulse: status write refused |
| status | output | 8 | Status byte {lock, 0, 0, 0, level[1:0], latch, busy} |

## Verification
The bench builds the block with ADDR_W set to 6, so the whole 64-entry address space can be swept under each of the four protection levels. Every boundary between fenced and open addresses is then hit directly, not sampled. At that width the quarter and half boundaries fall at 48 and 32, which the reference model derives from its own integer arithmetic.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'd0,
    PROT_QTR  = 2'd1,
    PROT_HALF = 2'd2,
    PROT_ALL  = 2'd3
  } prot_lvl_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SRW,
    OP_ARW,
    OP_ARM,
    OP_DISARM
  } op_e;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_LOCK = 7;
endpackage

// File: rtl/eewp_range.sv
module eewp_range
  import eewp_pkg::*;
(
  input  logic [1:0] top_bits,
  input  prot_lvl_e  level,
  output logic       fenced
);
  always_comb begin
    unique case (level)
      PROT_NONE: fenced = 1'b0;
      PROT_QTR:  fenced = (top_bits == 2'b11);
      PROT_HALF: fenced = top_bits[1];
      default:   fenced = 1'b1;
    endcase
  end
endmodule

// File: rtl/eewp_arb.sv
module eewp_arb
  import eewp_pkg::*;
(
  input  logic busy,
  input  logic cmd_sr_wr,
  input  logic cmd_wr_start,
  input  logic cmd_arm,
  input  logic cmd_disarm,
  output op_e  op
);
  always_comb begin
    op = OP_IDLE;
    if (!busy) begin
      if (cmd_sr_wr)         op = OP_SRW;
      else if (cmd_wr_start) op = OP_ARW;
      else if (cmd_arm)      op = OP_ARM;
      else if (cmd_disarm)   op = OP_DISARM;
    end
  end
endmodule

// File: rtl/eewp_state.sv
module eewp_state
  import eewp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_wel,
  input  logic      clr_wel,
  input  logic      start,
  input  logic      finish,
  input  logic      sr_load,
  input  prot_lvl_e sr_level,
  input  logic      sr_lock,
  output logic      wel,
  output logic      busy,
  output prot_lvl_e level,
  output logic      lock
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      busy  <= 1'b0;
      level <= PROT_NONE;
      lock  <= 1'b0;
    end else begin
      if (finish)       busy <= 1'b0;
      else if (start)   busy <= 1'b1;
      if (finish || clr_wel) wel <= 1'b0;
      else if (set_wel)      wel <= 1'b1;
      if (sr_load) begin
        level <= sr_level;
        lock  <= sr_lock;
      end
    end
  end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_wp_n,
  input  logic              cmd_arm,
  input  logic              cmd_disarm,
  input  logic              cmd_sr_wr,
  input  logic [7:0]        sr_din,
  input  logic              cmd_wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              cmd_wr_done,
  output logic              arr_grant,
  output logic              sr_grant,
  output logic              sr_reject,
  output logic [7:0]        status
);
  localparam int TOP_LSB = ADDR_W - 2;

  op_e       op;
  logic      wel, busy, lock, fenced;
  prot_lvl_e level;
  logic      sr_ok, sr_go, arr_go, finish;
  logic      unused_din;

  assign unused_din = ^{sr_din[6:4], sr_din[1:0]};

  eewp_arb u_arb (
    .busy(busy), .cmd_sr_wr(cmd_sr_wr), .cmd_wr_start(cmd_wr_start),
    .cmd_arm(cmd_arm), .cmd_disarm(cmd_disarm), .op(op)
  );

  eewp_range u_range (
    .top_bits(wr_addr[ADDR_W-1:TOP_LSB]), .level(level), .fenced(fenced)
  );

  // lock only bites while the pin is pulled low
  assign sr_ok  = wel && (!lock || hw_wp_n);
  assign sr_go  = (op == OP_SRW) && sr_ok;
  assign arr_go = (op == OP_ARW) && wel && !fenced;
  assign finish = busy && cmd_wr_done;

  eewp_state u_state (
    .clk(clk), .rst_n(rst_n),
    .set_wel(op == OP_ARM), .clr_wel(op == OP_DISARM),
    .start(sr_go || arr_go), .finish(finish),
    .sr_load(sr_go), .sr_level(prot_lvl_e'(sr_din[3:2])), .sr_lock(sr_din[7]),
    .wel(wel), .busy(busy), .level(level), .lock(lock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_grant <= 1'b0;
      sr_grant  <= 1'b0;
      sr_reject <= 1'b0;
    end else begin
      arr_grant <= arr_go;
      sr_grant  <= sr_go;
      sr_reject <= cmd_sr_wr && !sr_go;
    end
  end

  assign status = {lock, 3'b000, level, wel, busy};
endmodule

// File: rtl/eewp_chk.sv
module eewp_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_wp_n,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cmd_wr_done,
  input logic              arr_grant,
  input logic              sr_grant,
  input logic              sr_reject,
  input logic [7:0]        status
);
  logic              past_ok, p_pin, p_done;
  logic [ADDR_W-1:0] p_addr;
  logic [7:0]        p_st;
  logic              p_fenced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0; p_pin <= 1'b0; p_done <= 1'b0;
      p_addr <= '0; p_st <= '0;
    end else begin
      past_ok <= 1'b1; p_pin <= hw_wp_n; p_done <= cmd_wr_done;
      p_addr <= wr_addr; p_st <= status;
    end
  end

  always_comb begin
    case (p_st[3:2])
      2'd0:    p_fenced = 1'b0;
      2'd1:    p_fenced = &p_addr[ADDR_W-1 -: 2];
      2'd2:    p_fenced = p_addr[ADDR_W-1];
      default: p_fenced = 1'b1;
    endcase
  end

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_grant && sr_reject));
  assert_fence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && arr_grant) |-> !p_fenced);
  assert_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && arr_grant) |-> (p_st[1] && !p_st[0]));
  assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_grant || sr_grant) |-> status[0]);
  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && p_done && p_st[0]) |-> (status[1:0] == 2'b00));
  assert_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && p_st[7] && !p_pin) |-> (status[7] && !sr_grant));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && sr_reject) |-> (status[7:2] == p_st[7:2]));
  assert_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);
endmodule

bind eeprom_wp_ctrl eewp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_wp_n(hw_wp_n), .wr_addr(wr_addr),
  .cmd_wr_done(cmd_wr_done), .arr_grant(arr_grant), .sr_grant(sr_grant),
  .sr_reject(sr_reject), .status(status)
);

// File: tb/eeprom_wp_ctrl_tb.sv
module eeprom_wp_ctrl_tb;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1;
  logic arm = 0, disarm = 0, srw = 0, start = 0, done = 0;
  logic [7:0] din = 8'h00;
  logic [AW-1:0] addr = '0;
  logic arr_grant, sr_grant, sr_reject;
  logic [7:0] status;

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_wel = 0, m_busy = 0, m_lvl = 0, m_lock = 0;
  int e_ag = 0, e_sg = 0, e_sr = 0;

  always #10 clk = ~clk;

  eeprom_wp_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_wp_n(pin), .cmd_arm(arm), .cmd_disarm(disarm),
    .cmd_sr_wr(srw), .sr_din(din), .cmd_wr_start(start), .wr_addr(addr),
    .cmd_wr_done(done), .arr_grant(arr_grant), .sr_grant(sr_grant),
    .sr_reject(sr_reject), .status(status)
  );

  function automatic int fenced(int lvl, int a);
    if (lvl == 0) return 0;
    if (lvl == 1) return (a >= 48) ? 1 : 0;
    if (lvl == 2) return (a >= 32) ? 1 : 0;
    return 1;
  endfunction

  task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model follows the requirements, then compare at the negedge
  task automatic cyc(string tag, bit a_arm, bit a_dis, bit a_srw, logic [7:0] a_din,
                     bit a_st, bit a_done, int a_addr);
    int go_s, go_a;
    arm = a_arm; disarm = a_dis; srw = a_srw; din = a_din;
    start = a_st; done = a_done; addr = a_addr[AW-1:0];
    go_s = 0; go_a = 0;
    e_ag = 0; e_sg = 0; e_sr = 0;
    if (m_busy == 1) begin
      if (a_done) begin m_busy = 0; m_wel = 0; end
    end else if (a_srw) begin
      go_s = (m_wel == 1 && (m_lock == 0 || pin == 1'b1)) ? 1 : 0;
    end else if (a_st) begin
      go_a = (m_wel == 1 && fenced(m_lvl, a_addr) == 0) ? 1 : 0;
    end else if (a_arm) m_wel = 1;
    else if (a_dis) m_wel = 0;
    if (a_srw && go_s == 0) e_sr = 1;
    if (go_s == 1) begin
      e_sg = 1; m_busy = 1; m_lvl = (a_din >> 2) & 3; m_lock = a_din[7];
    end
    if (go_a == 1) begin e_ag = 1; m_busy = 1; end
    @(posedge clk);
    @(negedge clk);
    check(tag, {arr_grant, sr_grant, sr_reject, status},
          {e_ag[0], e_sg[0], e_sr[0], m_lock[0], 3'b000, m_lvl[1:0], m_wel[0], m_busy[0]});
    arm = 0; disarm = 0; srw = 0; start = 0; done = 0;
  endtask

  task automatic set_level(int lvl);
    pin = 1'b1;
    cyc("R9", 1, 0, 0, 0, 0, 0, 0);
    cyc("R9", 0, 0, 1, 8'(lvl << 2), 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {arr_grant, sr_grant, sr_reject, status}, 11'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {arr_grant, sr_grant, sr_reject, status}, 11'h000);

    cyc("R3", 0, 0, 0, 0, 1, 0, 0);            // unarmed write refused
    cyc("R2", 1, 0, 0, 0, 0, 0, 0);
    cyc("R2", 0, 1, 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 1, 8'h8C, 0, 0, 0);       // unarmed status write
    cyc("R2", 1, 0, 0, 0, 0, 0, 0);
    cyc("R3", 0, 0, 0, 0, 1, 0, 5);
    cyc("R5", 0, 1, 0, 0, 0, 0, 0);            // disarm ignored while busy
    cyc("R5", 0, 0, 1, 8'h0C, 0, 0, 0);        // status write refused while busy
    cyc("R5", 0, 0, 0, 0, 1, 0, 7);
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);            // idle done ignored

    cyc("R9", 1, 0, 0, 0, 0, 0, 0);
    cyc("R11", 0, 0, 1, 8'hF7, 0, 0, 0);       // lock=1, level=1, junk bits dropped
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0);
    cyc("R4", 0, 0, 0, 0, 1, 0, 50);
    cyc("R3", 0, 0, 0, 0, 1, 0, 40);
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);

    pin = 1'b0;
    cyc("R8", 1, 0, 0, 0, 0, 0, 0);
    cyc("R8", 0, 0, 1, 8'h00, 0, 0, 0);
    cyc("R8", 0, 0, 1, 8'h08, 0, 0, 0);
    pin = 1'b1;
    cyc("R9", 0, 0, 1, 8'h08, 0, 0, 0);        // lock cleared, level 2
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);
    pin = 1'b0;
    cyc("R7", 1, 0, 0, 0, 0, 0, 0);
    cyc("R7", 0, 0, 1, 8'h8C, 0, 0, 0);        // lock set with pin low, level 3
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);
    cyc("R4", 1, 0, 0, 0, 0, 0, 0);
    cyc("R4", 0, 0, 0, 0, 1, 0, 0);

    for (int lvl = 0; lvl < 4; lvl++) begin
      set_level(lvl);
      for (int a = 0; a < 64; a++) begin
        cyc("R4", 1, 0, 0, 0, 0, 0, 0);
        cyc("R4", 0, 0, 0, 0, 1, 0, a);
        cyc("R6", 0, 0, 0, 0, 0, 1, 0);
        cyc("R2", 0, 1, 0, 0, 0, 0, 0);
      end
    end

    set_level(0);
    cyc("R12", 1, 0, 1, 8'h04, 1, 0, 0);       // status write wins, refused, arm dropped
    cyc("R12", 1, 1, 0, 0, 0, 0, 0);           // arm beats disarm
    cyc("R12", 1, 0, 0, 0, 1, 0, 9);           // write start beats arm
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);
    cyc("R12", 1, 0, 0, 0, 0, 0, 0);
    cyc("R12", 0, 0, 1, 8'h04, 1, 0, 3);       // status write beats start
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule